// File: doc/BRIEF.md
# DMA Channel Handshake Front End

This block sits in front of one DMA channel's transfer engine. It decides where transaction requests come from on each side of the channel. The source side and the destination side are handled separately. Each side has its own mode bit. In hardware mode a peripheral index picks one of N request line pairs, one line for single and one for chunk. In software mode the requests come from two request bits per side, which the register logic sets with one-cycle pulses. A side flagged as memory takes no part in the handshake and always shows a ready chunk request to the engine.

Each side is run by a three-state machine:
- **IDLE** waits for a request. It moves to **PEND** when a single or chunk request is seen, and a chunk request wins over a single one. On that move it latches the kind of request, the mode and the peripheral index.
- **PEND** shows the latched request to the engine. It moves to **ACK** when the engine signals that the transaction is done.
- **ACK** lasts one cycle. In hardware mode it pulses the acknowledge line of the latched peripheral. In software mode it clears the software bit that was served. It then returns to **IDLE**.

A memory endpoint stays in IDLE.

Top module: `dma_hs_front`

## Requirements
- R1: After reset, neither side presents a request (unless it is flagged as memory), every `hw_ack` line is low, and all software request bits read 0.
- R2: In hardware mode (`*_hw_sel`=1), a request on `hw_sreq`/`hw_creq` at bit `*_pidx` makes `*_req_vld` high from the next clock edge. Requests on any other line have no effect.
- R3: `*_req_chunk` is 1 for a chunk transaction and 0 for a single one. When both kinds are requested in the same cycle, the chunk request is served.
- R4: One clock edge after `*_done` is sampled high while the side is pending, the side pulses an acknowledge for exactly one cycle. In hardware mode this is `hw_ack[latched index]` alone, and all other ack lines stay low.
- R5: While a side is pending, it ignores new requests and changes to the index or mode inputs. The acknowledge goes to the peripheral that was latched when the request was accepted.
- R6: In software mode (`*_hw_sel`=0), set pulses on `*_sw_sset`/`*_sw_cset` set the software request bits (`*_sw_bits` bit 0 = single, bit 1 = chunk). These bits drive the request, hardware request lines are ignored, and no `hw_ack` line rises.
- R7: A software request bit clears itself as the side leaves ACK, and only the bit of the kind that was served is cleared. A bit that is still set is served next.
- R8: A side flagged as memory (`*_is_mem`=1) holds `*_req_vld`=1 and `*_req_chunk`=1. It ignores hardware lines and `*_done`, and it never drives an acknowledge.
- R9: The source and destination sides run independently, each with its own mode and index. Both can be pending at once, and each side is acknowledged on its own line.
- R10: Software set pulses that arrive while the side is not in IDLE are discarded.
- R11: A hardware index of N or more selects no line, so no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_hw_sel | input | 1 | Source mode: 1 = hardware lines, 0 = software bits |
| src_is_mem | input | 1 | Source is memory; handshake bypassed |
| src_pidx | input | PW | Source peripheral index |
| dst_hw_sel | input | 1 | Destination mode: 1 = hardware lines, 0 = software bits |
| dst_is_mem | input | 1 | Destination is memory; handshake bypassed |
| dst_pidx | input | PW | Destination peripheral index |
| hw_sreq | input | N | Single request line per peripheral |
| hw_creq | input | N | Chunk request line per peripheral |
| hw_ack | output | N | Acknowledge line per peripheral |
| src_sw_sset | input | 1 | Pulse that sets the source software single bit |
| src_sw_cset | input | 1 | Pulse that sets the source software chunk bit |
| dst_sw_sset | input | 1 | Pulse that sets the destination software single bit |
| dst_sw_cset | input | 1 | Pulse that sets the destination software chunk bit |
| src_done | input | 1 | Engine finished the source transaction |
| dst_done | input | 1 | Engine finished the destination transaction |
| src_req_vld | output | 1 | Source request presented to the engine |
| src_req_chunk | output | 1 | Source request kind: 1 chunk, 0 single |
| dst_req_vld | output | 1 | Destination request presented to the engine |
| dst_req_chunk | output | 1 | Destination request kind: 1 chunk, 0 single |
| src_sw_bits | output | 2 | Source software request bits {chunk, single} |
| dst_sw_bits | output | 2 | Destination software request bits {chunk, single} |

## Verification
The bench builds the block with N = 6, so the index is three bits wide. This lets indices 6 and 7 reach the out-of-range guard. Six lines are still enough to show that an acknowledge lands on exactly one chosen line while the others stay low. The two sides are given different peripherals, so the bench can observe their independence directly on the shared `hw_ack` bus.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_PEND = 2'd1,
        HS_ACK  = 2'd2
    } hs_state_e;
endpackage

// File: rtl/hs_onehot.sv
module hs_onehot #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [W-1:0] idx,
    input  logic         en,
    output logic [N-1:0] vec
);
    for (genvar i = 0; i < N; i++) begin : g_dec
        assign vec[i] = en && (idx == W'(i));
    end
endmodule

// File: rtl/hs_side.sv
module hs_side
    import dma_hs_pkg::*;
#(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hw_sel,
    input  logic         is_mem,
    input  logic [W-1:0] pidx,
    input  logic [N-1:0] hw_sreq,
    input  logic [N-1:0] hw_creq,
    input  logic         sw_sset,
    input  logic         sw_cset,
    input  logic         xfer_done,
    output logic         req_vld,
    output logic         req_chunk,
    output logic [N-1:0] ack_vec,
    output logic [1:0]   sw_bits
);
    hs_state_e    state_q, state_d;
    logic         kind_q;
    logic         hw_q;
    logic [W-1:0] idx_q;
    logic         sw_s_q, sw_c_q;
    logic         idx_ok, sel_s, sel_c, go;
    logic         ack_en;

    // request mux: hardware line pair or software bits
    assign idx_ok = (32'(pidx) < N);
    assign sel_s  = hw_sel ? (idx_ok && hw_sreq[pidx]) : sw_s_q;
    assign sel_c  = hw_sel ? (idx_ok && hw_creq[pidx]) : sw_c_q;

    always_comb begin
        state_d = state_q;
        go      = 1'b0;
        unique case (state_q)
            HS_IDLE: if (!is_mem && (sel_s || sel_c)) begin
                state_d = HS_PEND;
                go      = 1'b1;
            end
            HS_PEND: if (xfer_done) state_d = HS_ACK;
            HS_ACK:  state_d = HS_IDLE;
            default: state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    // latched context of the accepted request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= 1'b0;
            hw_q   <= 1'b0;
            idx_q  <= '0;
        end else if (go) begin
            kind_q <= sel_c;
            hw_q   <= hw_sel;
            idx_q  <= pidx;
        end
    end

    // software request bits: set only while idle, self-clear on ack
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_s_q <= 1'b0;
            sw_c_q <= 1'b0;
        end else if (state_q == HS_IDLE) begin
            sw_s_q <= sw_s_q | sw_sset;
            sw_c_q <= sw_c_q | sw_cset;
        end else if (state_q == HS_ACK && !hw_q) begin
            if (kind_q) sw_c_q <= 1'b0;
            else        sw_s_q <= 1'b0;
        end
    end

    always_comb begin
        req_vld   = is_mem;
        req_chunk = is_mem;
        ack_en    = 1'b0;
        unique case (state_q)
            HS_IDLE: ;
            HS_PEND: begin
                req_vld   = 1'b1;
                req_chunk = kind_q;
            end
            HS_ACK:  ack_en = hw_q;
            default: ;
        endcase
    end

    hs_onehot #(.N(N)) u_dec (
        .idx (idx_q),
        .en  (ack_en),
        .vec (ack_vec)
    );

    assign sw_bits = {sw_c_q, sw_s_q};
endmodule

// File: rtl/dma_hs_front.sv
module dma_hs_front #(
    parameter int N = 8,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_hw_sel,
    input  logic          src_is_mem,
    input  logic [PW-1:0] src_pidx,
    input  logic          dst_hw_sel,
    input  logic          dst_is_mem,
    input  logic [PW-1:0] dst_pidx,
    input  logic [N-1:0]  hw_sreq,
    input  logic [N-1:0]  hw_creq,
    output logic [N-1:0]  hw_ack,
    input  logic          src_sw_sset,
    input  logic          src_sw_cset,
    input  logic          dst_sw_sset,
    input  logic          dst_sw_cset,
    input  logic          src_done,
    input  logic          dst_done,
    output logic          src_req_vld,
    output logic          src_req_chunk,
    output logic          dst_req_vld,
    output logic          dst_req_chunk,
    output logic [1:0]    src_sw_bits,
    output logic [1:0]    dst_sw_bits
);
    logic [N-1:0] src_ack_vec;
    logic [N-1:0] dst_ack_vec;

    hs_side #(.N(N)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_sel    (src_hw_sel),
        .is_mem    (src_is_mem),
        .pidx      (src_pidx),
        .hw_sreq   (hw_sreq),
        .hw_creq   (hw_creq),
        .sw_sset   (src_sw_sset),
        .sw_cset   (src_sw_cset),
        .xfer_done (src_done),
        .req_vld   (src_req_vld),
        .req_chunk (src_req_chunk),
        .ack_vec   (src_ack_vec),
        .sw_bits   (src_sw_bits)
    );

    hs_side #(.N(N)) u_dst (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_sel    (dst_hw_sel),
        .is_mem    (dst_is_mem),
        .pidx      (dst_pidx),
        .hw_sreq   (hw_sreq),
        .hw_creq   (hw_creq),
        .sw_sset   (dst_sw_sset),
        .sw_cset   (dst_sw_cset),
        .xfer_done (dst_done),
        .req_vld   (dst_req_vld),
        .req_chunk (dst_req_chunk),
        .ack_vec   (dst_ack_vec),
        .sw_bits   (dst_sw_bits)
    );

    assign hw_ack = src_ack_vec | dst_ack_vec;
endmodule

// File: rtl/dma_hs_front_chk.sv
module dma_hs_front_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] src_ack,
    input logic [N-1:0] dst_ack,
    input logic         src_done,
    input logic         dst_done,
    input logic         src_req_vld,
    input logic         dst_req_vld,
    input logic         src_is_mem,
    input logic         dst_is_mem
);
    // R4
    src_ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ack));
    // R4
    dst_ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dst_ack));
    // R4
    src_ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_ack) |=> !(|src_ack));
    // R4
    dst_ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dst_ack) |=> !(|dst_ack));
    // R4
    src_ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_ack) |-> $past(src_done && src_req_vld));
    // R4
    dst_ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dst_ack) |-> $past(dst_done && dst_req_vld));
    // R8
    src_mem_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_is_mem |-> src_req_vld);
    // R8
    dst_mem_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_is_mem |-> dst_req_vld);
endmodule

bind dma_hs_front dma_hs_front_chk #(.N(N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_ack     (src_ack_vec),
    .dst_ack     (dst_ack_vec),
    .src_done    (src_done),
    .dst_done    (dst_done),
    .src_req_vld (src_req_vld),
    .dst_req_vld (dst_req_vld),
    .src_is_mem  (src_is_mem),
    .dst_is_mem  (dst_is_mem)
);

// File: tb/dma_hs_front_bench.sv
`timescale 1ns/100ps
module dma_hs_front_bench;
    localparam int NP = 6;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          src_hw_sel = 1'b1, src_is_mem = 1'b0;
    logic          dst_hw_sel = 1'b1, dst_is_mem = 1'b0;
    logic [PW-1:0] src_pidx = '0, dst_pidx = '0;
    logic [NP-1:0] hw_sreq = '0, hw_creq = '0, hw_ack;
    logic          src_sw_sset = 0, src_sw_cset = 0, dst_sw_sset = 0, dst_sw_cset = 0;
    logic          src_done = 0, dst_done = 0;
    logic          src_req_vld, src_req_chunk, dst_req_vld, dst_req_chunk;
    logic [1:0]    src_sw_bits, dst_sw_bits;

    int n_cmp = 0;
    int n_mis = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    dma_hs_front #(.N(NP)) u_dma_hs_front (
        .clk(clk), .rst_n(rst_n),
        .src_hw_sel(src_hw_sel), .src_is_mem(src_is_mem), .src_pidx(src_pidx),
        .dst_hw_sel(dst_hw_sel), .dst_is_mem(dst_is_mem), .dst_pidx(dst_pidx),
        .hw_sreq(hw_sreq), .hw_creq(hw_creq), .hw_ack(hw_ack),
        .src_sw_sset(src_sw_sset), .src_sw_cset(src_sw_cset),
        .dst_sw_sset(dst_sw_sset), .dst_sw_cset(dst_sw_cset),
        .src_done(src_done), .dst_done(dst_done),
        .src_req_vld(src_req_vld), .src_req_chunk(src_req_chunk),
        .dst_req_vld(dst_req_vld), .dst_req_chunk(dst_req_chunk),
        .src_sw_bits(src_sw_bits), .dst_sw_bits(dst_sw_bits)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    endtask

    task automatic t_reset();
        chk("R1", "src_req_vld", 32'(src_req_vld), 0);
        chk("R1", "dst_req_vld", 32'(dst_req_vld), 0);
        chk("R1", "hw_ack", 32'(hw_ack), 0);
        chk("R1", "sw bits", 32'({src_sw_bits, dst_sw_bits}), 0);
    endtask

    task automatic t_hw_single();
        src_hw_sel = 1; src_pidx = 3'd2;
        hw_sreq[4] = 1'b1;
        step();
        chk("R2", "other line ignored", 32'(src_req_vld), 0);
        hw_sreq[4] = 1'b0; hw_sreq[2] = 1'b1;
        step();
        chk("R2", "req_vld", 32'(src_req_vld), 1);
        chk("R3", "single kind", 32'(src_req_chunk), 0);
        src_done = 1;
        step();
        src_done = 0; hw_sreq[2] = 1'b0;
        chk("R4", "ack on line 2", 32'(hw_ack), 32'h04);
        step();
        chk("R4", "ack one cycle", 32'(hw_ack), 0);
        chk("R4", "back idle", 32'(src_req_vld), 0);
    endtask

    task automatic t_chunk_wins();
        src_pidx = 3'd3;
        hw_sreq[3] = 1; hw_creq[3] = 1;
        step();
        step();
        chk("R3", "chunk wins", 32'(src_req_chunk), 1);
        src_done = 1;
        step();
        src_done = 0; hw_sreq[3] = 0; hw_creq[3] = 0;
        chk("R4", "ack on line 3", 32'(hw_ack), 32'h08);
        step();
    endtask

    task automatic t_pending_hold();
        src_pidx = 3'd1; hw_sreq[1] = 1;
        step();
        step();
        src_pidx = 3'd5; hw_creq[5] = 1;
        step();
        chk("R5", "kind held", 32'(src_req_chunk), 0);
        chk("R5", "still pending", 32'(src_req_vld), 1);
        src_done = 1;
        step();
        src_done = 0; hw_sreq[1] = 0; hw_creq[5] = 0;
        chk("R5", "ack to latched line", 32'(hw_ack), 32'h02);
        step();
    endtask

    task automatic t_sw_both();
        dst_hw_sel = 0; dst_pidx = 3'd0;
        hw_sreq[0] = 1;
        dst_sw_sset = 1; dst_sw_cset = 1;
        step();
        dst_sw_sset = 0; dst_sw_cset = 0;
        chk("R6", "bits set", 32'(dst_sw_bits), 3);
        chk("R6", "not yet pending", 32'(dst_req_vld), 0);
        step();
        chk("R6", "sw pending", 32'(dst_req_vld), 1);
        chk("R3", "sw chunk wins", 32'(dst_req_chunk), 1);
        dst_done = 1;
        step();
        dst_done = 0;
        chk("R6", "no hw ack in sw mode", 32'(hw_ack), 0);
        step();
        chk("R7", "chunk bit cleared", 32'(dst_sw_bits), 1);
        step();
        chk("R7", "single served next", 32'({dst_req_vld, dst_req_chunk}), 2);
        dst_done = 1;
        step();
        dst_done = 0;
        step();
        chk("R7", "all bits clear", 32'(dst_sw_bits), 0);
        hw_sreq[0] = 0;
        step();
        chk("R6", "hw line ignored", 32'(dst_req_vld), 0);
    endtask

    task automatic t_sw_late_set();
        dst_sw_cset = 1;
        step();
        dst_sw_cset = 0;
        step();
        chk("R10", "pending", 32'(dst_req_vld), 1);
        dst_sw_sset = 1;
        step();
        dst_sw_sset = 0;
        chk("R10", "late set discarded", 32'(dst_sw_bits), 2);
        dst_done = 1;
        step();
        dst_done = 0;
        step();
        chk("R10", "bits after ack", 32'(dst_sw_bits), 0);
        step();
        chk("R10", "no new request", 32'(dst_req_vld), 0);
        dst_hw_sel = 1;
    endtask

    task automatic t_mem();
        src_is_mem = 1; src_pidx = 3'd2; hw_sreq[2] = 1;
        #0.5;
        chk("R8", "mem ready", 32'({src_req_vld, src_req_chunk}), 3);
        src_done = 1;
        step();
        src_done = 0;
        step();
        chk("R8", "mem no ack", 32'(hw_ack), 0);
        chk("R8", "mem still ready", 32'({src_req_vld, src_req_chunk}), 3);
        hw_sreq[2] = 0; src_is_mem = 0;
        step();
        chk("R8", "leaves idle side", 32'(src_req_vld), 0);
    endtask

    task automatic t_indep();
        src_pidx = 3'd4; hw_creq[4] = 1;
        dst_pidx = 3'd1; hw_sreq[1] = 1;
        step();
        step();
        chk("R9", "both pending", 32'({src_req_vld, src_req_chunk, dst_req_vld, dst_req_chunk}), 4'b1110);
        src_done = 1;
        step();
        src_done = 0; hw_creq[4] = 0;
        chk("R9", "src ack only", 32'(hw_ack), 32'h10);
        chk("R9", "dst still pending", 32'(dst_req_vld), 1);
        dst_done = 1;
        step();
        dst_done = 0; hw_sreq[1] = 0;
        chk("R9", "dst ack only", 32'(hw_ack), 32'h02);
        step();
    endtask

    task automatic t_range();
        src_pidx = 3'd7;
        hw_sreq = '1; hw_creq = '1;
        step();
        step();
        chk("R11", "out of range index", 32'(src_req_vld), 0);
        chk("R11", "no ack", 32'(hw_ack), 0);
        hw_sreq = '0; hw_creq = '0;
        step();
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_mis++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step();
        step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_hw_single();
        t_chunk_wins();
        t_pending_hold();
        t_sw_both();
        t_sw_late_set();
        t_mem();
        t_indep();
        t_range();
        finish_run();
    end
endmodule